// File: doc/BRIEF.md
# Boot Configuration Fetch Sequencer

This block runs right after a processor core leaves reset. It reads the bus control settings of the boot memory region out of a small boot record in memory, then latches them as that region's configuration. Until that configuration is latched, the region counts as 8 bits wide. Each of the four fetch reads is a single byte at a word-aligned address, and the byte is taken from data bits [7:0]. This lane is correct whether the memory behind the controller is 8 or 32 bits wide. The width bits found in the record then govern every later access to the region.

A power-up strap can keep only the core in reset, while the rest of the device stays up. A host can then preload memory through its own path, and afterwards clear a host-writable hold bit to let the core go. No fetch starts while that bit is set. After the fourth byte arrives, the block asserts a config-valid output and stays done until the next full reset. Setting the hold bit again after release has no effect.

Top module: `boot_cfg_seq`

## Requirements
- R1: During reset and directly after it, rd_req, cfg_valid and width_32 are 0, cfg_word is 0, and the hold bit takes the value of strap_hold.
- R2: While the hold bit is 1, core_held is 1 and no read is requested. A host write of 0 (hold_wr_en=1, hold_wr_data=0) clears the bit on that clock edge. The first read request appears one clock edge later, and core_held falls with it.
- R3: Exactly four reads are issued per reset, to 0xFEFFFF30, 0xFEFFFF34, 0xFEFFFF38 and 0xFEFFFF3C, in that order. Every fetch address is word-aligned.
- R4: A request and its address stay steady until rd_rvalid is sampled high, with no limit on wait states. The next address is presented on the following cycle. An rd_rvalid that arrives while no request is pending leaves cfg_word unchanged.
- R5: Only rd_rdata[7:0] is captured. The byte of read n (n = 0..3) goes to cfg_word[8n+7:8n], so the first read fills bits [7:0] and the last fills bits [31:24].
- R6: width_32 is 1 only when cfg_valid is 1 and cfg_word[1:0] = 2'b10. The codes 00, 01 and 11 all mean 8-bit (width_32 = 0), and before cfg_valid the region is 8-bit.
- R7: cfg_valid rises on the clock edge that accepts the fourth byte. It and cfg_word then hold steady until the next reset.
- R8: Once the fetch has started, writing the hold bit back to 1 starts no new read and does not change cfg_valid or cfg_word.
- R9: With strap_hold = 0 at reset, the fetch starts on the first clock edge after reset with no host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hold | input | 1 | Power-up strap, reset value of the hold bit |
| hold_wr_en | input | 1 | Host write strobe for the hold bit |
| hold_wr_data | input | 1 | Value written to the hold bit |
| core_held | output | 1 | Core still held, fetch not yet started |
| rd_req | output | 1 | Byte read request, held until the response |
| rd_addr | output | 32 | Address of the pending byte read |
| rd_rvalid | input | 1 | Read response valid strobe |
| rd_rdata | input | 32 | Read data, only bits [7:0] used |
| cfg_word | output | 32 | Assembled region control word |
| cfg_valid | output | 1 | Control word latched and final |
| width_32 | output | 1 | Region decoded as 32 bits wide |

## Verification
The bench runs the fetch once for each of the four width codes in the first byte, so that 10 can be told apart from the other three codes, which all give 8-bit. It mixes zero and long wait-state patterns, which separates "held until response" from a fixed-latency assumption. It puts nonzero values on the upper data lanes, which exposes a wrong lane or a wrong byte order. Strap-held runs add rvalid pulses that arrive while no read is pending, a host release whose one-cycle start latency is checked, and a re-set of the hold bit after completion. Strap-clear runs show that the fetch starts with no host write.

// File: rtl/boot_cfg_pkg.sv
// Package: shared types and constants for the boot configuration fetch sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package boot_cfg_pkg;

    // Sequencer phase: held, fetching bytes, configuration latched.
    typedef enum logic [1:0] {
        SEQ_HELD  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

    // Region width codes carried in control word bits [1:0].
    localparam logic [1:0] WCODE_8  = 2'b00;
    localparam logic [1:0] WCODE_32 = 2'b10;

    // Byte lane width used during the bootstrap reads.
    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/bcs_hold_bit.sv
// Module: host-writable hold bit that keeps the core in reset.
// Assumes: the strap is stable while reset is asserted; host writes are single-cycle strobes.
module bcs_hold_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_hold,
    input  logic wr_en,
    input  logic wr_data,
    output logic hold_q
);

    // Load the strap at reset, then follow host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= strap_hold;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

endmodule

// File: rtl/bcs_fetch_ctrl.sv
// Module: control FSM that waits for release, then walks the fixed boot record addresses.
// Assumes: one outstanding read at a time; a response is a one-cycle rvalid strobe.
module bcs_fetch_ctrl
    import boot_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_READS = 4,
    parameter logic [31:0] BASE_ADDR = 32'hFEFF_FF30,
    parameter int unsigned STRIDE    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hold,
    input  logic                         rvalid,
    output logic                         rd_req,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic                         byte_take,
    output logic [$clog2(NUM_READS)-1:0] byte_idx,
    output logic                         seq_done,
    output logic                         core_held
);

    localparam int unsigned IDX_W = $clog2(NUM_READS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next-state and index logic for the fetch walk.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        case (state_q)
            SEQ_HELD: begin
                if (!hold) begin
                    state_d = SEQ_FETCH;
                    idx_d   = '0;
                end
            end
            SEQ_FETCH: begin
                if (rvalid) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = SEQ_DONE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            SEQ_DONE: begin
                state_d = SEQ_DONE;
            end
            default: begin
                state_d = SEQ_HELD;
                idx_d   = '0;
            end
        endcase
    end

    // State and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_HELD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        rd_req    = (state_q == SEQ_FETCH);
        byte_take = rd_req && rvalid;
        byte_idx  = idx_q;
        seq_done  = (state_q == SEQ_DONE);
        core_held = (state_q == SEQ_HELD);
        rd_addr   = ADDR_W'(BASE_ADDR) + ADDR_W'(idx_q) * ADDR_W'(STRIDE);
    end

    AST_NO_REQ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold && core_held |=> !rd_req); // R2

    AST_REQ_HELD_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rvalid |=> rd_req && $stable(rd_addr)); // R4

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[1:0] == 2'b00); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done && !rd_req); // R7

endmodule

// File: rtl/bcs_word_asm.sv
// Module: packs the low-lane bytes of the bootstrap reads into the control word.
// Assumes: byte_idx counts up from 0; take is high for exactly one cycle per byte.
module bcs_word_asm
    import boot_cfg_pkg::*;
#(
    parameter int unsigned NUM_READS = 4,
    parameter int unsigned WORD_W    = NUM_READS * LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [$clog2(NUM_READS)-1:0] idx,
    input  logic [LANE_W-1:0]            lane,
    output logic [WORD_W-1:0]            word
);

    localparam int unsigned IDX_W = $clog2(NUM_READS);

    for (genvar g = 0; g < NUM_READS; g++) begin : g_slice
        // Capture the lane byte into slice g when its read completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word[g*LANE_W +: LANE_W] <= '0;
            end else if (take && idx == IDX_W'(g)) begin
                word[g*LANE_W +: LANE_W] <= lane;
            end
        end
    end

    AST_WORD_FROZEN_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(word)); // R4

endmodule

// File: rtl/bcs_width_dec.sv
// Module: decodes the region width from the latched control word.
// Assumes: the code is meaningful only once the word is valid.
module bcs_width_dec
    import boot_cfg_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] code,
    output logic       width_32
);

    // Only the 32-bit code widens the region; every other code stays byte wide.
    always_comb begin
        width_32 = valid && (code == WCODE_32);
    end

endmodule

// File: rtl/boot_cfg_seq.sv
// Module: top of the boot configuration fetch sequencer.
// Assumes: the memory port returns one response per request; rd_rdata is valid with rd_rvalid.
module boot_cfg_seq
    import boot_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_READS = 4,
    parameter logic [31:0] BASE_ADDR = 32'hFEFF_FF30,
    parameter int unsigned STRIDE    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strap_hold,
    input  logic                          hold_wr_en,
    input  logic                          hold_wr_data,
    output logic                          core_held,
    output logic                          rd_req,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_rvalid,
    input  logic [DATA_W-1:0]             rd_rdata,
    output logic [NUM_READS*LANE_W-1:0]   cfg_word,
    output logic                          cfg_valid,
    output logic                          width_32
);

    localparam int unsigned IDX_W = $clog2(NUM_READS);

    logic             hold_q;
    logic             byte_take;
    logic [IDX_W-1:0] byte_idx;
    logic             unused_upper_lanes;

    // Upper lanes carry nothing during the byte-wide bootstrap reads.
    assign unused_upper_lanes = ^rd_rdata[DATA_W-1:LANE_W];

    bcs_hold_bit u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_hold(strap_hold),
        .wr_en    (hold_wr_en),
        .wr_data  (hold_wr_data),
        .hold_q   (hold_q)
    );

    bcs_fetch_ctrl #(
        .ADDR_W   (ADDR_W),
        .NUM_READS(NUM_READS),
        .BASE_ADDR(BASE_ADDR),
        .STRIDE   (STRIDE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_q),
        .rvalid   (rd_rvalid),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .byte_take(byte_take),
        .byte_idx (byte_idx),
        .seq_done (cfg_valid),
        .core_held(core_held)
    );

    bcs_word_asm #(
        .NUM_READS(NUM_READS)
    ) u_asm (
        .clk  (clk),
        .rst_n(rst_n),
        .take (byte_take),
        .idx  (byte_idx),
        .lane (rd_rdata[LANE_W-1:0]),
        .word (cfg_word)
    );

    bcs_width_dec u_wdec (
        .valid   (cfg_valid),
        .code    (cfg_word[1:0]),
        .width_32(width_32)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid && $stable(cfg_word) && $stable(width_32)); // R7

    AST_REHOLD_NO_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && hold_wr_en |=> !rd_req && !core_held); // R8

    AST_NARROW_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !width_32); // R6

endmodule

// File: tb/boot_cfg_seq_tb.sv
`timescale 1ns/1ps
module boot_cfg_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hold = 1'b1;
    logic        hold_wr_en = 1'b0;
    logic        hold_wr_data = 1'b0;
    logic        core_held;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic [31:0] cfg_word;
    logic        cfg_valid;
    logic        width_32;

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    bit spur_en = 1'b0;

    logic [31:0] exp_addr_q[$];
    logic [7:0]  exp_byte_q[$];
    int          exp_wait_q[$];

    always #2 clk = ~clk;

    boot_cfg_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_hold  (strap_hold),
        .hold_wr_en  (hold_wr_en),
        .hold_wr_data(hold_wr_data),
        .core_held   (core_held),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_rvalid   (rd_rvalid),
        .rd_rdata    (rd_rdata),
        .cfg_word    (cfg_word),
        .cfg_valid   (cfg_valid),
        .width_32    (width_32)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor and memory model: pops expected address, waits, answers with junk upper lanes.
    initial begin
        forever begin
            @(negedge clk);
            rd_rvalid = 1'b0;
            if (rst_n && rd_req) begin
                logic [31:0] ea;
                logic [7:0]  eb;
                int          ew;
                if (exp_addr_q.size() == 0) begin
                    chk("R8 unexpected request", rd_addr, 32'h0);
                    ea = rd_addr; eb = 8'h00; ew = 0;
                end else begin
                    ea = exp_addr_q.pop_front();
                    eb = exp_byte_q.pop_front();
                    ew = exp_wait_q.pop_front();
                end
                chk("R3 read address", rd_addr, ea);
                chk("R7 not valid early", {31'b0, cfg_valid}, 32'h0);
                for (int i = 0; i < ew; i++) begin
                    @(negedge clk);
                    chk("R4 request held", {rd_req, rd_addr[30:0]}, {1'b1, ea[30:0]});
                end
                rd_rvalid = 1'b1;
                rd_rdata  = {~eb, 8'hA5, eb ^ 8'h3C, eb};
                nreads++;
                if (exp_addr_q.size() == 0) begin
                    @(negedge clk);
                    rd_rvalid = 1'b0;
                    chk("R7 valid after fourth byte", {31'b0, cfg_valid}, 32'h1);
                end
            end else if (spur_en && !rd_req) begin
                rd_rvalid = 1'b1;
                rd_rdata  = 32'hFFFF_FF5A;
            end
        end
    end

    // Driver: resets, pushes expectations, optionally releases, then checks results.
    task automatic run_boot(input bit strap, input logic [31:0] bytes, input logic [31:0] waits);
        logic [31:0] exp_word;
        int cnt;
        rst_n = 1'b0;
        strap_hold = strap;
        hold_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_req in reset", {31'b0, rd_req}, 32'h0);
        chk("R1 cfg_valid in reset", {31'b0, cfg_valid}, 32'h0);
        chk("R1 width_32 in reset", {31'b0, width_32}, 32'h0);
        chk("R1 cfg_word in reset", cfg_word, 32'h0);
        exp_word = '0;
        for (int n = 0; n < 4; n++) begin
            exp_addr_q.push_back(32'hFEFF_FF30 + 32'(n * 4));
            exp_byte_q.push_back(bytes[n*8 +: 8]);
            exp_wait_q.push_back(int'(waits[n*8 +: 8]));
            exp_word[n*8 +: 8] = bytes[n*8 +: 8];
        end
        nreads = 0;
        rst_n = 1'b1;
        if (strap) begin
            spur_en = 1'b1;
            repeat (6) @(negedge clk);
            spur_en = 1'b0;
            @(negedge clk);
            chk("R4 stray rvalid ignored", cfg_word, 32'h0);
            chk("R2 core held", {31'b0, core_held}, 32'h1);
            chk("R2 no read while held", 32'(nreads), 32'h0);
            hold_wr_en = 1'b1;
            hold_wr_data = 1'b0;
            @(negedge clk);
            hold_wr_en = 1'b0;
            chk("R2 start one edge after clear", {30'b0, rd_req, core_held}, 32'h1);
            @(negedge clk);
            chk("R2 request after release", {30'b0, rd_req, core_held}, 32'h2);
        end else begin
            @(negedge clk);
            chk("R9 strap clear starts fetch", {30'b0, rd_req, core_held}, 32'h2);
        end
        cnt = 0;
        while (!cfg_valid && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        @(negedge clk);
        chk("R3 four reads", 32'(nreads), 32'h4);
        chk("R5 assembled word", cfg_word, exp_word);
        chk("R6 width decode", {31'b0, width_32}, {31'b0, exp_word[1:0] == 2'b10});
        if (strap) begin
            hold_wr_en = 1'b1;
            hold_wr_data = 1'b1;
            @(negedge clk);
            hold_wr_en = 1'b0;
            repeat (10) @(negedge clk);
            chk("R8 no rerun", 32'(nreads), 32'h4);
            chk("R8 word kept", cfg_word, exp_word);
            chk("R7 valid kept", {30'b0, cfg_valid, core_held}, 32'h2);
        end
    endtask

    initial begin
        run_boot(1'b1, 32'h1234_56A2, 32'h05_01_03_00);
        run_boot(1'b0, 32'hC0DE_7703, 32'h00_00_00_00);
        run_boot(1'b0, 32'h8899_AA01, 32'h02_00_07_01);
        run_boot(1'b1, 32'hFF00_FF00, 32'h00_09_00_02);
        run_boot(1'b0, 32'h0F1E_2D3E, 32'h01_01_01_01);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule